// File: doc/BRIEF.md
# Three-State Mealy Machine with Tester Commands

This block is a small Mealy machine with three states, numbered 1 to 3, and two functional input symbols, `a` and `b`. Each accepted functional symbol produces a one-bit output and moves the machine along a fixed transition table. State 1 is the home state.

On top of the functional table the block accepts three tester commands. Home returns the machine to state 1. Probe reports the current state index without moving the machine. Jump places the machine directly in a chosen state. With these commands an external tester can reach any state, apply one functional symbol, and then read back the state the machine ended in. This is enough to confirm every output and every transition in the table.

Commands arrive as a valid strobe with an opcode and a state-index field. Results leave on registered outputs one cycle later.

Top module: `mealy3_testctl`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, the next cycle finds the machine in state 1 with `rsp_vld`, `rsp_bit` and `rsp_idx` all low. This holds whatever command is presented.
- R2: Opcode 3'b000 (symbol `a`) keeps the state unchanged. Its output is 0 in state 1, 1 in state 2 and 0 in state 3.
- R3: Opcode 3'b001 (symbol `b`) moves the machine from state 1 to 2 with output 1, from 2 to 3 with output 1, and from 3 to 1 with output 0.
- R4: `rsp_vld` is high for exactly the one cycle after an accepted `a`, `b` or probe command. It is low in every other cycle.
- R5: Opcode 3'b011 (probe) returns the current state index (1, 2 or 3) on `rsp_idx` in the following cycle and leaves the state unchanged.
- R6: Opcode 3'b010 (home) moves the machine to state 1 from any state and raises no response.
- R7: Opcode 3'b100 (jump) with `cmd_idx` equal to 1, 2 or 3 moves the machine to that state and raises no response.
- R8: A jump whose `cmd_idx` is 0 leaves the state unchanged and raises no response.
- R9: While `cmd_vld` is low, nothing changes and no response is raised. Opcodes 3'b101 to 3'b111 are ignored in the same way.
- R10: `rsp_bit` is 0 in any cycle that is not a response to `a` or `b`. `rsp_idx` is 0 in any cycle that is not a response to a probe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 000 a, 001 b, 010 home, 011 probe, 100 jump |
| cmd_idx | input | 2 | Target state index for jump |
| rsp_vld | output | 1 | Response valid, one cycle after a, b or probe |
| rsp_bit | output | 1 | Functional output of the a or b transition |
| rsp_idx | output | 2 | State index returned by probe |

## Verification
Every result is registered. The response and the new state both become visible one cycle after the command is sampled. A state change made by home or jump has no response of its own, so it can only be observed through a probe one further cycle on.

The bench drives each command on a falling edge and compares the outputs on the next falling edge, so exactly one rising edge separates stimulus from check. A probe follows every silent command and every transition whose destination matters. The commands that must leave the state alone are checked the same way: a probe after an ignored strobe, an unknown opcode or a jump to index 0 must return the unchanged state.

// File: rtl/mealy3_testctl.sv
module mealy3_testctl #(
  parameter int OPW = 3,
  parameter int IXW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_vld,
  input  logic [OPW-1:0] cmd_op,
  input  logic [IXW-1:0] cmd_idx,
  output logic           rsp_vld,
  output logic           rsp_bit,
  output logic [IXW-1:0] rsp_idx
);

  localparam logic [OPW-1:0] OP_A     = OPW'(0);
  localparam logic [OPW-1:0] OP_B     = OPW'(1);
  localparam logic [OPW-1:0] OP_HOME  = OPW'(2);
  localparam logic [OPW-1:0] OP_PROBE = OPW'(3);
  localparam logic [OPW-1:0] OP_JUMP  = OPW'(4);
  localparam logic [IXW-1:0] ST1 = IXW'(1);
  localparam logic [IXW-1:0] ST2 = IXW'(2);
  localparam logic [IXW-1:0] ST3 = IXW'(3);

  logic [IXW-1:0] cur, nxt;
  logic           fn_out;

  wire is_a     = cmd_vld && cmd_op == OP_A;
  wire is_b     = cmd_vld && cmd_op == OP_B;
  wire is_home  = cmd_vld && cmd_op == OP_HOME;
  wire is_probe = cmd_vld && cmd_op == OP_PROBE;
  wire is_jump  = cmd_vld && cmd_op == OP_JUMP && cmd_idx != '0;

  always_comb begin
    nxt    = cur;
    fn_out = 1'b0;
    if (is_a) begin
      nxt    = cur;
      fn_out = (cur == ST2);
    end else if (is_b) begin
      case (cur)
        ST1:     begin nxt = ST2; fn_out = 1'b1; end
        ST2:     begin nxt = ST3; fn_out = 1'b1; end
        default: begin nxt = ST1; fn_out = 1'b0; end
      endcase
    end else if (is_home) begin
      nxt = ST1;
    end else if (is_jump) begin
      nxt = cmd_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= ST1;
      rsp_vld <= 1'b0;
      rsp_bit <= 1'b0;
      rsp_idx <= '0;
    end else begin
      cur     <= nxt;
      rsp_vld <= is_a || is_b || is_probe;
      rsp_bit <= (is_a || is_b) && fn_out;
      rsp_idx <= is_probe ? cur : '0;
    end
  end

endmodule

module mealy3_testctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_vld,
  input logic [2:0] cmd_op,
  input logic [1:0] cmd_idx,
  input logic       rsp_vld,
  input logic       rsp_bit,
  input logic [1:0] rsp_idx,
  input logic [1:0] cur
);

  // R1
  hw_reset_chk: assert property (@(posedge clk)
    rst |=> (cur == 2'd1 && !rsp_vld && !rsp_bit && rsp_idx == 2'd0));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && (cmd_op == 3'd0 || cmd_op == 3'd1 || cmd_op == 3'd3)) |=> rsp_vld);

  // R4
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_vld && (cmd_op == 3'd0 || cmd_op == 3'd1 || cmd_op == 3'd3)) |=> !rsp_vld);

  // R5
  probe_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == 3'd3) |=> (rsp_idx == $past(cur) && $stable(cur)));

  // R6
  home_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == 3'd2) |=> cur == 2'd1);

  // R8
  jump_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == 3'd4 && cmd_idx == 2'd0) |=> $stable(cur));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_vld || cmd_op > 3'd4) |=> $stable(cur));

  // R10
  rsp_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> (!rsp_bit && rsp_idx == 2'd0));

endmodule

bind mealy3_testctl mealy3_testctl_chk i_chk (
  .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
  .rsp_vld(rsp_vld), .rsp_bit(rsp_bit), .rsp_idx(rsp_idx), .cur(cur)
);

// File: tb/test_mealy3_testctl.sv
module test_mealy3_testctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_vld;
  logic [2:0] cmd_op;
  logic [1:0] cmd_idx;
  logic       rsp_vld, rsp_bit;
  logic [1:0] rsp_idx;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mealy3_testctl i_mealy3_testctl (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .rsp_vld(rsp_vld), .rsp_bit(rsp_bit), .rsp_idx(rsp_idx)
  );

  // {op[3], idx[2], exp_vld, exp_bit, exp_idx[2], req[4]}
  localparam int NV = 25;
  localparam logic [12:0] VEC [NV] = '{
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd1, 4'd5},  // R5 probe in s1
    {3'd0, 2'd0, 1'b1, 1'b0, 2'd0, 4'd2},  // R2 a in s1
    {3'd1, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 b s1->s2
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd2, 4'd5},  // R5
    {3'd0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd2},  // R2 a in s2
    {3'd1, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 b s2->s3
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd3, 4'd5},  // R5
    {3'd0, 2'd0, 1'b1, 1'b0, 2'd0, 4'd2},  // R2 a in s3
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd3, 4'd2},  // R2 stays in s3
    {3'd1, 2'd0, 1'b1, 1'b0, 2'd0, 4'd3},  // R3 b s3->s1
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd1, 4'd3},  // R3
    {3'd4, 2'd3, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 jump 3
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd3, 4'd7},  // R7
    {3'd2, 2'd0, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 home
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd1, 4'd6},  // R6
    {3'd4, 2'd2, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 jump 2
    {3'd4, 2'd0, 1'b0, 1'b0, 2'd0, 4'd8},  // R8 jump 0
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd2, 4'd8},  // R8
    {3'd5, 2'd1, 1'b0, 1'b0, 2'd0, 4'd9},  // R9 unknown opcode
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd2, 4'd9},  // R9
    {3'd4, 2'd1, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 jump 1
    {3'd1, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3
    {3'd1, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3
    {3'd1, 2'd0, 1'b1, 1'b0, 2'd0, 4'd10}, // R10 bit low with valid high
    {3'd3, 2'd0, 1'b1, 1'b0, 2'd1, 4'd4}   // R4
  };

  task automatic check(input logic ev, input logic eb, input logic [1:0] ei, input string tag);
    tests++;
    if (rsp_vld !== ev || rsp_bit !== eb || rsp_idx !== ei) begin
      fails++;
      $display("FAIL %s: got vld=%b bit=%b idx=%0d, expected vld=%b bit=%b idx=%0d",
               tag, rsp_vld, rsp_bit, rsp_idx, ev, eb, ei);
    end
  endtask

  task automatic cmd(input logic v, input logic [2:0] op, input logic [1:0] ix,
                     input logic ev, input logic eb, input logic [1:0] ei, input string tag);
    cmd_vld = v; cmd_op = op; cmd_idx = ix;
    @(negedge clk);
    check(ev, eb, ei, tag);
  endtask

  initial begin
    rst = 1'b1; cmd_vld = 1'b0; cmd_op = 3'd0; cmd_idx = 2'd0;
    repeat (2) @(negedge clk);
    check(1'b0, 1'b0, 2'd0, "R1 reset outputs");
    rst = 1'b0;
    cmd(1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 2'd1, "R1 reset state s1");

    for (int k = 0; k < NV; k++) begin
      cmd(1'b1, VEC[k][12:10], VEC[k][9:8], VEC[k][7], VEC[k][6], VEC[k][5:4],
          $sformatf("R%0d vector %0d", VEC[k][3:0], k));
    end

    cmd(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 2'd0, "R4 response lasts one cycle");
    cmd(1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 2'd0, "R9 strobe low b ignored");
    cmd(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 2'd0, "R9 strobe low probe ignored");
    cmd(1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 2'd1, "R9 state kept with strobe low");
    cmd(1'b1, 3'd7, 2'd3, 1'b0, 1'b0, 2'd0, "R9 opcode 7 ignored");
    cmd(1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 2'd1, "R9 state kept after opcode 7");

    cmd(1'b1, 3'd4, 2'd3, 1'b0, 1'b0, 2'd0, "R7 jump 3 silent");
    rst = 1'b1;
    cmd(1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 2'd0, "R1 reset overrides b");
    rst = 1'b0;
    cmd(1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 2'd1, "R1 state s1 after mid-run reset");

    cmd(1'b1, 3'd4, 2'd3, 1'b0, 1'b0, 2'd0, "R7 jump 3");
    cmd(1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 2'd0, "R6 home from s3 silent");
    cmd(1'b1, 3'd0, 2'd0, 1'b1, 1'b0, 2'd0, "R2 a in s1 after home");
    cmd(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 2'd0, "R10 idle outputs clean");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule